// File: doc/BRIEF.md
# AHB Slave Address Decoder with Built-in Error Responder

This block turns the address phase of one AHB-Lite master into slave selects. Each of N slave regions is described by a start address and by the number of low address bits that slave resolves on its own. A region is hit when the address bits above that count equal the same bits of the start address. Only fixed masks and equality tests are used, so there is no adder and no magnitude compare on the select path.

When a transfer that is not IDLE hits no region, the block selects its own default responder. For NONSEQ and SEQ transfers, the responder returns the standard two-cycle AHB ERROR. For BUSY transfers it returns a zero-wait OKAY. The direction of the transfer plays no part: the block has no write-enable input.

The select outputs are combinational from the address, because AHB needs the select in the same address phase. The responder's ready and response outputs come straight from flip-flops. The block is placed between a master, or one layer of an interconnect, and the slave multiplexer that uses its selects.

Top module: `ahb_region_decoder`

## Requirements
- R1: `hsel[k]` is high exactly when the bits of `haddr` at positions `LOW_BITS[k]` and above equal the same bits of `START_ADDRS[k]`. It does not depend on `htrans` or `hready`.
- R2: At most one bit of `{hsel, hsel_dflt}` is high at any time. When regions overlap, only the lowest-index hit is asserted.
- R3: `hsel_dflt` is high exactly when no region is hit and `htrans` is not IDLE. The `htrans` encoding is IDLE=00, BUSY=01, NONSEQ=10, SEQ=11.
- R4: While `rst` is high, and on the first clock after it falls, `dflt_hreadyout`=1 and `dflt_hresp`=0.
- R5: A NONSEQ or SEQ transfer is accepted by the responder when `hsel_dflt`=1, `hready`=1 and `dflt_hreadyout`=1 at a rising edge. After that edge the responder gives `dflt_hreadyout`=0 and `dflt_hresp`=1 for one cycle, then `dflt_hreadyout`=1 and `dflt_hresp`=1 for one cycle, then OKAY (1, 0) unless a new transfer was accepted.
- R6: A BUSY transfer accepted under the same conditions leaves the response at OKAY with no wait state.
- R7: A transfer with `hsel_dflt`=1 and `hready`=0 is not accepted: the response stays at OKAY.
- R8: A NONSEQ or SEQ transfer accepted during the second ERROR cycle starts a new two-cycle ERROR straight away.
- R9: Inputs present during the first ERROR cycle (the wait cycle) do not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| haddr | input | ADDR_W | Address-phase address |
| htrans | input | 2 | Transfer type |
| hready | input | 1 | Bus ready; high means an address phase is taken |
| hsel | output | NUM_SLV | One-hot slave selects |
| hsel_dflt | output | 1 | Default responder select |
| dflt_hreadyout | output | 1 | Default responder ready |
| dflt_hresp | output | 1 | Default responder response (1 = ERROR) |

## Verification
The bench applies the first and the last address of every region and of every gap.

- A mask built one bit short or one bit long, or a compare that includes the low bits, would select the wrong slave, or none, at one of those edges.
- A second instance is built with overlapping regions. A design that lacks the lowest-index priority would raise two selects there.
- The ERROR sequence is driven with NONSEQ and with SEQ, and also back to back from the second error cycle. A responder that returns to idle too early, or that skips the wait cycle, would disagree with the reference model in that cycle.
- BUSY transfers, transfers held with `hready` low, and new requests during the wait cycle are also applied. A responder that latched any of these would show a spurious ERROR or wait state.

// File: rtl/ahb_region_decoder_pkg.sv
`timescale 1ns/1ps
package ahb_region_decoder_pkg;

  localparam int MAX_ADDR_W = 64;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'd0,
    RSP_WAIT  = 2'd1,
    RSP_FINAL = 2'd2
  } rsp_state_t;

  // Constant mask keeping address bits at positions >= low_bits
  function automatic logic [MAX_ADDR_W-1:0] upper_mask(input int low_bits);
    logic [MAX_ADDR_W-1:0] m;
    for (int i = 0; i < MAX_ADDR_W; i++) begin
      m[i] = (i >= low_bits);
    end
    return m;
  endfunction

endpackage

// File: rtl/region_match.sv
`timescale 1ns/1ps
module region_match #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter int                LOW_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import ahb_region_decoder_pkg::*;

  localparam logic [MAX_ADDR_W-1:0] FULL_MASK = upper_mask(LOW_BITS);
  localparam logic [ADDR_W-1:0]     KEEP      = FULL_MASK[ADDR_W-1:0];

  // equality on the kept upper bits only; no arithmetic
  always_comb begin
    hit = (((addr ^ BASE) & KEEP) == '0);
  end

endmodule

// File: rtl/priority_pick.sv
`timescale 1ns/1ps
module priority_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_chain
      assign grant[k]   = req[k] & ~taken[k];
      assign taken[k+1] = taken[k] | req[k];
    end
  endgenerate

  assign any = taken[N];

endmodule

// File: rtl/error_responder.sv
`timescale 1ns/1ps
module error_responder (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic active_xfer,
  input  logic hready,
  output logic hreadyout,
  output logic hresp
);
  import ahb_region_decoder_pkg::*;

  rsp_state_t state_q, state_d;
  logic       take;

  // address phase is taken only when the bus is ready
  assign take = sel & hready & active_xfer;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RSP_OKAY:  state_d = take ? RSP_WAIT : RSP_OKAY;
      RSP_WAIT:  state_d = RSP_FINAL;
      RSP_FINAL: state_d = take ? RSP_WAIT : RSP_OKAY;
      default:   state_d = RSP_OKAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RSP_OKAY;
      hreadyout <= 1'b1;
      hresp     <= 1'b0;
    end else begin
      state_q   <= state_d;
      hreadyout <= (state_d != RSP_WAIT);
      hresp     <= (state_d != RSP_OKAY);
    end
  end

endmodule

// File: rtl/ahb_region_decoder.sv
`timescale 1ns/1ps
module ahb_region_decoder #(
  parameter int                             ADDR_W      = 16,
  parameter int                             NUM_SLV     = 4,
  parameter logic [NUM_SLV-1:0][ADDR_W-1:0] START_ADDRS = {16'h8000, 16'h4000, 16'h1000, 16'h0000},
  parameter logic [NUM_SLV-1:0][7:0]        LOW_BITS    = {8'd14, 8'd13, 8'd12, 8'd12}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hready,
  output logic [NUM_SLV-1:0] hsel,
  output logic               hsel_dflt,
  output logic               dflt_hreadyout,
  output logic               dflt_hresp
);
  import ahb_region_decoder_pkg::*;

  logic [NUM_SLV-1:0] raw_hit;
  logic               any_hit;

  generate
    for (genvar k = 0; k < NUM_SLV; k++) begin : g_region
      region_match #(
        .ADDR_W  (ADDR_W),
        .BASE    (START_ADDRS[k]),
        .LOW_BITS(int'(LOW_BITS[k]))
      ) u_match (
        .addr(haddr),
        .hit (raw_hit[k])
      );
    end
  endgenerate

  priority_pick #(.N(NUM_SLV)) u_pick (
    .req  (raw_hit),
    .grant(hsel),
    .any  (any_hit)
  );

  assign hsel_dflt = ~any_hit & (htrans != TR_IDLE);

  error_responder u_err (
    .clk        (clk),
    .rst        (rst),
    .sel        (hsel_dflt),
    .active_xfer(htrans[1]),
    .hready     (hready),
    .hreadyout  (dflt_hreadyout),
    .hresp      (dflt_hresp)
  );

endmodule

// File: rtl/ahb_region_decoder_chk.sv
`timescale 1ns/1ps
module ahb_region_decoder_chk #(
  parameter int NUM_SLV = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         htrans,
  input logic               hready,
  input logic [NUM_SLV-1:0] hsel,
  input logic               hsel_dflt,
  input logic               dflt_hreadyout,
  input logic               dflt_hresp
);

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hsel, hsel_dflt}));

  // R3
  idle_no_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b00) |-> !hsel_dflt);

  // R5
  err_first_chk: assert property (@(posedge clk) disable iff (rst)
    (hsel_dflt && hready && htrans[1] && dflt_hreadyout) |=> (!dflt_hreadyout && dflt_hresp));

  // R5
  err_second_chk: assert property (@(posedge clk) disable iff (rst)
    !dflt_hreadyout |=> (dflt_hreadyout && dflt_hresp));

  // R6
  busy_okay_chk: assert property (@(posedge clk) disable iff (rst)
    (hsel_dflt && hready && htrans == 2'b01 && dflt_hreadyout && !dflt_hresp) |=> (dflt_hreadyout && !dflt_hresp));

  // R7
  held_okay_chk: assert property (@(posedge clk) disable iff (rst)
    (!hready && dflt_hreadyout && !dflt_hresp) |=> (dflt_hreadyout && !dflt_hresp));

endmodule

bind ahb_region_decoder ahb_region_decoder_chk #(.NUM_SLV(NUM_SLV)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .htrans        (htrans),
  .hready        (hready),
  .hsel          (hsel),
  .hsel_dflt     (hsel_dflt),
  .dflt_hreadyout(dflt_hreadyout),
  .dflt_hresp    (dflt_hresp)
);

// File: tb/ahb_region_decoder_bench.sv
`timescale 1ns/1ps
module ahb_region_decoder_bench;

  localparam logic [3:0][15:0] ST_A = {16'h8000, 16'h4000, 16'h1000, 16'h0000};
  localparam logic [3:0][7:0]  W_A  = {8'd14, 8'd13, 8'd12, 8'd12};
  localparam logic [3:0][15:0] ST_B = {16'h8000, 16'h4000, 16'h0000, 16'h0000};
  localparam logic [3:0][7:0]  W_B  = {8'd14, 8'd13, 8'd13, 8'd12};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] t_addr = '0;
  logic [1:0]  t_trans = 2'b00;
  logic        t_rdy = 1'b1;

  logic [3:0] hsel_a, hsel_b;
  logic       dflt_a, dflt_b, rdy_a, rdy_b, rsp_a, rsp_b;

  int checks = 0;
  int errors = 0;
  int phase  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ahb_region_decoder u_ahb_region_decoder (
    .clk(clk), .rst(rst), .haddr(t_addr), .htrans(t_trans), .hready(t_rdy),
    .hsel(hsel_a), .hsel_dflt(dflt_a), .dflt_hreadyout(rdy_a), .dflt_hresp(rsp_a)
  );

  ahb_region_decoder #(.START_ADDRS(ST_B), .LOW_BITS(W_B)) u_ovl (
    .clk(clk), .rst(rst), .haddr(t_addr), .htrans(t_trans), .hready(t_rdy),
    .hsel(hsel_b), .hsel_dflt(dflt_b), .dflt_hreadyout(rdy_b), .dflt_hresp(rsp_b)
  );

  // range-based reference: start <= a < start + 2**w, first hit wins
  function automatic logic [3:0] ref_sel(input logic [15:0] a,
                                         input logic [3:0][15:0] st,
                                         input logic [3:0][7:0] w);
    logic [3:0] r = '0;
    bit found = 0;
    for (int k = 0; k < 4; k++) begin
      if (!found && int'(a) >= int'(st[k]) && int'(a) < int'(st[k]) + (1 << w[k])) begin
        r[k] = 1'b1;
        found = 1;
      end
    end
    return r;
  endfunction

  function automatic logic ref_dflt(input logic [15:0] a, input logic [1:0] t,
                                    input logic [3:0][15:0] st, input logic [3:0][7:0] w);
    return (ref_sel(a, st, w) == 4'b0) && (t != 2'b00);
  endfunction

  // behavioural response model: 0 okay, 1 wait+error, 2 final error
  always @(posedge clk) begin
    if (rst) phase <= 0;
    else if (phase == 1) phase <= 2;
    else if (t_rdy && t_trans[1] && ref_dflt(t_addr, t_trans, ST_A, W_A)) phase <= 1;
    else phase <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // drive one address phase, check decode, then check the registered response
  task automatic step(input logic [15:0] a, input logic [1:0] t, input logic r, input string tag);
    t_addr = a; t_trans = t; t_rdy = r;
    #1;
    chk({"R1 ", tag}, 32'(hsel_a), 32'(ref_sel(a, ST_A, W_A)));
    chk({"R3 ", tag}, 32'(dflt_a), 32'(ref_dflt(a, t, ST_A, W_A)));
    chk({"R2 ", tag}, 32'(hsel_b), 32'(ref_sel(a, ST_B, W_B)));
    chk({"R3 ", tag}, 32'(dflt_b), 32'(ref_dflt(a, t, ST_B, W_B)));
    @(negedge clk);
    chk({"rsp ", tag}, {30'b0, rdy_a, rsp_a}, {30'b0, phase != 1, phase != 0});
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) begin
      @(negedge clk);
      chk("R4 in reset", {30'b0, rdy_a, rsp_a}, 32'b10);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R4 after reset", {30'b0, rdy_a, rsp_a}, 32'b10);

    // R1 region and gap edges with IDLE
    foreach (ST_A[k]) begin end
    step(16'h0000, 2'b00, 1'b1, "R1 s0 low");
    step(16'h0FFF, 2'b00, 1'b1, "R1 s0 high");
    step(16'h1000, 2'b00, 1'b1, "R1 s1 low");
    step(16'h1FFF, 2'b00, 1'b1, "R1 s1 high");
    step(16'h2000, 2'b00, 1'b1, "R1 gap low");
    step(16'h3FFF, 2'b00, 1'b1, "R1 gap high");
    step(16'h4000, 2'b10, 1'b1, "R1 s2 low");
    step(16'h5FFF, 2'b11, 1'b1, "R1 s2 high");
    step(16'h6000, 2'b00, 1'b0, "R1 gap2");
    step(16'h7FFF, 2'b00, 1'b1, "R1 gap2 high");
    step(16'h8000, 2'b10, 1'b0, "R1 s3 low");
    step(16'hBFFF, 2'b10, 1'b1, "R1 s3 high");
    step(16'hC000, 2'b00, 1'b1, "R1 top gap");
    step(16'hFFFF, 2'b00, 1'b1, "R1 top end");

    // R2 overlap region in the second instance
    step(16'h0800, 2'b10, 1'b1, "R2 overlap low");
    step(16'h1800, 2'b10, 1'b1, "R2 overlap upper");

    // R5 NONSEQ error sequence
    step(16'h2000, 2'b10, 1'b1, "R5 accept");
    step(16'h0000, 2'b00, 1'b1, "R5 wait");
    step(16'h0000, 2'b00, 1'b1, "R5 final");
    step(16'h0000, 2'b00, 1'b1, "R5 okay");
    // R5 SEQ to a gap
    step(16'hFFFC, 2'b11, 1'b1, "R5 seq accept");
    step(16'h0000, 2'b00, 1'b1, "R5 seq wait");
    step(16'h0000, 2'b00, 1'b1, "R5 seq final");

    // R6 BUSY to a gap
    step(16'h6004, 2'b01, 1'b1, "R6 busy");
    step(16'h6004, 2'b01, 1'b1, "R6 busy again");

    // R7 held address phase
    step(16'h3000, 2'b10, 1'b0, "R7 held");
    step(16'h3000, 2'b10, 1'b0, "R7 held again");

    // R8 back-to-back: accept, wait (bus not ready), accept in final cycle
    step(16'h3000, 2'b10, 1'b1, "R8 first");
    step(16'h3000, 2'b10, 1'b0, "R8 wait");
    step(16'h3004, 2'b10, 1'b1, "R8 second accept");
    step(16'h0000, 2'b00, 1'b1, "R8 second wait");
    step(16'h0000, 2'b00, 1'b1, "R8 second final");

    // R9 request during wait cycle is ignored
    step(16'hD000, 2'b10, 1'b1, "R9 accept");
    step(16'hD000, 2'b10, 1'b1, "R9 in wait");
    step(16'h0000, 2'b00, 1'b1, "R9 final");
    step(16'h0000, 2'b00, 1'b1, "R9 okay");

    finish_run();
  end

endmodule